// File: doc/BRIEF.md
# Multi-Bank Binary Search Tuner

This block runs the coarse frequency acquisition of a digitally tuned oscillator that is split into several tuning banks, ordered from coarsest to finest. It searches each bank in turn by bisection. Once per reference cycle it takes a three-way verdict from a frequency detector (oscillator too slow, too fast, or within the detector's resolution), moves the active bank's tuning word, and holds every other bank's word steady. Each bank is left at a word that keeps the oscillator below the target frequency, so that the finer banks, which can only add frequency, can make up the rest.

A bank is finished in one of two ways. Either the bracket closes to two neighbouring words and the lower one is kept, or the detector reports that the error is within resolution. On the second exit, the word one below the applied word is kept, so that the bank stays on the slow side. Each time a bank search begins, the block asks the phase path for a zero-phase restart. When the last bank finishes, the block issues a one-cycle close-loop command and holds a done flag. The loop filter then takes over.

Detector verdicts arrive on a valid/ready interface. Ready is high only while a search runs. The producer may hold a verdict until it is accepted. A verdict offered while ready is low is not consumed, and the block does nothing with it. The start pulse is a plain control input. It takes priority over a verdict in the same cycle, and that verdict is then discarded.

Top module: `bst_tuner`

## Requirements
- R1: After reset, every tuning word is 0, and `done_o`, `cmp_ready_o`, `restart_o` and `close_loop_o` are all 0.
- R2: A `start_i` pulse, at any time, leaves bank 0's word at floor((2^bits(0)−1)/2), which is 15 for 5 bits, and every other bank at 0. In the next cycle it also gives a one-cycle `restart_o`, a low `done_o` and a high `cmp_ready_o`.
- R3: Verdict code 2'b01 (too slow) sets the lower bound to the applied word. Code 2'b10 (too fast) sets the upper bound to the applied word. When the bounds do not yet differ by one, the next applied word is floor((lower+upper)/2).
- R4: When lower+1 equals upper, the bank is frozen at the lower bound. The next bank then starts at the midpoint of its full range, and `restart_o` pulses.
- R5: On a non-final bank, code 2'b00 (within resolution) freezes the applied word minus one, saturating at 0. The next bank then starts as in R4.
- R6: On the final bank, code 2'b00 freezes the applied word and a closed bracket freezes the lower bound. Either way `close_loop_o` pulses for one cycle, `done_o` rises and stays high until the next start, and `cmp_ready_o` falls.
- R7: An accepted verdict with code 2'b11 changes nothing.
- R8: Banks already searched keep their frozen words. Banks not yet searched stay at 0.
- R9: A bank needs at most bits(j) accepted verdicts, so a whole acquisition takes at most the sum of the bank widths.
- R10: `cmp_ready_o` is high only while searching. A verdict offered without ready has no effect. A start in the same cycle as a verdict wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin acquisition from bank 0 |
| cmp_valid_i | input | 1 | Detector verdict valid |
| cmp_code_i | input | 2 | Verdict: 00 within, 01 slow, 10 fast, 11 none |
| cmp_ready_o | output | 1 | Verdict accepted this cycle when valid |
| tune_o | output | NUM_BANKS*MAX_W | Tuning words, bank j at bits [j*MAX_W +: MAX_W] |
| restart_o | output | 1 | Zero-phase restart request, one cycle |
| close_loop_o | output | 1 | Hand-over to closed-loop tracking, one cycle |
| done_o | output | 1 | Acquisition finished, held until next start |

## Verification
On every cycle, the assertions check these rules:
- A start gives a restart, with ready high and done low, on the following cycle.
- A code-11 verdict leaves all tuning words still.
- Restart and close never occur together.
- Done rises only with close, and ready stays low while done.
- No bank takes more verdicts than the widest bank's width.

The bisection values themselves can only be shown by the bench's directed scenarios. These cover the midpoints after each verdict, the back-off on the within-resolution exit, the frozen and untouched banks, and the exit from the final bank.

// File: rtl/bst_pkg.sv
`timescale 1ns/1ps
package bst_pkg;
  typedef enum logic [1:0] {
    CMP_HIT  = 2'b00,
    CMP_SLOW = 2'b01,
    CMP_FAST = 2'b10,
    CMP_NONE = 2'b11
  } cmp_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SEARCH = 2'b01,
    ST_DONE   = 2'b10
  } st_e;
endpackage

// File: rtl/bst_step.sv
`timescale 1ns/1ps
module bst_step #(
  parameter int MAX_W = 7
) (
  input  logic [MAX_W-1:0] lo_i,
  input  logic [MAX_W-1:0] hi_i,
  input  logic [MAX_W-1:0] cur_i,
  input  logic [1:0]       code_i,
  output logic [MAX_W-1:0] lo_o,
  output logic [MAX_W-1:0] hi_o,
  output logic             found_o,
  output logic [MAX_W-1:0] mid_o,
  output logic [MAX_W-1:0] backoff_o
);
  import bst_pkg::*;

  logic [MAX_W:0] sum;

  always_comb begin
    lo_o = (code_i == CMP_SLOW) ? cur_i : lo_i;
    hi_o = (code_i == CMP_FAST) ? cur_i : hi_i;
    found_o = (({1'b0, lo_o} + {{MAX_W{1'b0}}, 1'b1}) == {1'b0, hi_o});
    sum = {1'b0, lo_o} + {1'b0, hi_o};
    mid_o = sum[MAX_W:1];
    backoff_o = (cur_i == '0) ? '0 : cur_i - {{(MAX_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/bst_bank_store.sv
`timescale 1ns/1ps
module bst_bank_store #(
  parameter int NUM_BANKS = 3,
  parameter int MAX_W     = 7,
  parameter int BIDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       wr_i,
  input  logic [BIDX_W-1:0]          wr_bank_i,
  input  logic [MAX_W-1:0]           wr_word_i,
  input  logic                       live_i,
  input  logic [BIDX_W-1:0]          live_bank_i,
  input  logic [MAX_W-1:0]           live_word_i,
  output logic [NUM_BANKS*MAX_W-1:0] tune_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [MAX_W-1:0] frz_q;
    logic             is_live;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frz_q <= '0;
      end else if (clr_i) begin
        frz_q <= '0;
      end else if (wr_i && (wr_bank_i == BIDX_W'(b))) begin
        frz_q <= wr_word_i;
      end
    end

    assign is_live = live_i && (live_bank_i == BIDX_W'(b));
    assign tune_o[b*MAX_W +: MAX_W] = is_live ? live_word_i : frz_q;
  end
endmodule

// File: rtl/bst_ctrl.sv
`timescale 1ns/1ps
module bst_ctrl #(
  parameter int                     NUM_BANKS   = 3,
  parameter logic [NUM_BANKS*8-1:0] BANK_WIDTHS = {8'd7, 8'd5, 8'd5},
  parameter int                     MAX_W       = 7,
  parameter int                     BIDX_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_valid_i,
  input  logic [1:0]        cmp_code_i,
  output logic              cmp_ready_o,
  output logic              restart_o,
  output logic              close_o,
  output logic              done_o,
  output logic              clr_o,
  output logic              wr_o,
  output logic [BIDX_W-1:0] wr_bank_o,
  output logic [MAX_W-1:0]  wr_word_o,
  output logic              live_o,
  output logic [BIDX_W-1:0] live_bank_o,
  output logic [MAX_W-1:0]  live_word_o
);
  import bst_pkg::*;

  localparam logic [BIDX_W-1:0] LAST_BANK = BIDX_W'(NUM_BANKS - 1);

  function automatic logic [MAX_W-1:0] top_of(input logic [BIDX_W-1:0] idx);
    logic [MAX_W-1:0] ones;
    int               w;
    ones = '1;
    if (int'(idx) >= NUM_BANKS) return '0;
    w = int'(BANK_WIDTHS[int'(idx)*8 +: 8]);
    return ones >> (MAX_W - w);
  endfunction

  st_e              st_q, st_d;
  logic [BIDX_W-1:0] bank_q, bank_d, nb;
  logic [MAX_W-1:0]  lo_q, lo_d, hi_q, hi_d, cur_q, cur_d;
  logic              restart_q, restart_d, close_q, close_d, done_q, done_d;
  logic              acc, last, bank_exit;
  logic [MAX_W-1:0]  lo_n, hi_n, mid_n, backoff;
  logic              found;

  bst_step #(.MAX_W(MAX_W)) u_step (
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .cur_i     (cur_q),
    .code_i    (cmp_code_i),
    .lo_o      (lo_n),
    .hi_o      (hi_n),
    .found_o   (found),
    .mid_o     (mid_n),
    .backoff_o (backoff)
  );

  assign cmp_ready_o = (st_q == ST_SEARCH);
  assign acc         = cmp_valid_i && cmp_ready_o;
  assign last        = (bank_q == LAST_BANK);
  assign nb          = bank_q + {{(BIDX_W-1){1'b0}}, 1'b1};
  assign bank_exit   = (cmp_code_i == CMP_HIT) || found;

  always_comb begin
    st_d      = st_q;
    bank_d    = bank_q;
    lo_d      = lo_q;
    hi_d      = hi_q;
    cur_d     = cur_q;
    restart_d = 1'b0;
    close_d   = 1'b0;
    done_d    = done_q;
    clr_o     = 1'b0;
    wr_o      = 1'b0;
    wr_word_o = '0;
    if (start_i) begin
      clr_o     = 1'b1;
      st_d      = ST_SEARCH;
      bank_d    = '0;
      lo_d      = '0;
      hi_d      = top_of('0);
      cur_d     = top_of('0) >> 1;
      restart_d = 1'b1;
      done_d    = 1'b0;
    end else if (acc && (cmp_code_i != CMP_NONE)) begin
      if (!bank_exit) begin
        lo_d  = lo_n;
        hi_d  = hi_n;
        cur_d = mid_n;
      end else begin
        wr_o = 1'b1;
        if (cmp_code_i == CMP_HIT) wr_word_o = last ? cur_q : backoff;
        else                       wr_word_o = lo_n;
        if (last) begin
          st_d    = ST_DONE;
          close_d = 1'b1;
          done_d  = 1'b1;
        end else begin
          bank_d    = nb;
          lo_d      = '0;
          hi_d      = top_of(nb);
          cur_d     = top_of(nb) >> 1;
          restart_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bank_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      cur_q     <= '0;
      restart_q <= 1'b0;
      close_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      bank_q    <= bank_d;
      lo_q      <= lo_d;
      hi_q      <= hi_d;
      cur_q     <= cur_d;
      restart_q <= restart_d;
      close_q   <= close_d;
      done_q    <= done_d;
    end
  end

  assign restart_o   = restart_q;
  assign close_o     = close_q;
  assign done_o      = done_q;
  assign wr_bank_o   = bank_q;
  assign live_o      = (st_q == ST_SEARCH);
  assign live_bank_o = bank_q;
  assign live_word_o = cur_q;
endmodule

// File: rtl/bst_tuner.sv
`timescale 1ns/1ps
module bst_tuner #(
  parameter int                     NUM_BANKS   = 3,
  parameter logic [NUM_BANKS*8-1:0] BANK_WIDTHS = {8'd7, 8'd5, 8'd5}
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start_i,
  input  logic                                     cmp_valid_i,
  input  logic [1:0]                               cmp_code_i,
  output logic                                     cmp_ready_o,
  output logic [NUM_BANKS*widest_bank()-1:0]       tune_o,
  output logic                                     restart_o,
  output logic                                     close_loop_o,
  output logic                                     done_o
);
  function automatic int widest_bank();
    int m;
    m = 2;
    for (int i = 0; i < NUM_BANKS; i++)
      if (int'(BANK_WIDTHS[i*8 +: 8]) > m) m = int'(BANK_WIDTHS[i*8 +: 8]);
    return m;
  endfunction

  localparam int MAX_W  = widest_bank();
  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              clr, wr, live;
  logic [BIDX_W-1:0] wr_bank, live_bank;
  logic [MAX_W-1:0]  wr_word, live_word;

  bst_ctrl #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK_WIDTHS (BANK_WIDTHS),
    .MAX_W       (MAX_W),
    .BIDX_W      (BIDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_valid_i (cmp_valid_i),
    .cmp_code_i  (cmp_code_i),
    .cmp_ready_o (cmp_ready_o),
    .restart_o   (restart_o),
    .close_o     (close_loop_o),
    .done_o      (done_o),
    .clr_o       (clr),
    .wr_o        (wr),
    .wr_bank_o   (wr_bank),
    .wr_word_o   (wr_word),
    .live_o      (live),
    .live_bank_o (live_bank),
    .live_word_o (live_word)
  );

  bst_bank_store #(
    .NUM_BANKS (NUM_BANKS),
    .MAX_W     (MAX_W),
    .BIDX_W    (BIDX_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .wr_i        (wr),
    .wr_bank_i   (wr_bank),
    .wr_word_i   (wr_word),
    .live_i      (live),
    .live_bank_i (live_bank),
    .live_word_i (live_word),
    .tune_o      (tune_o)
  );
endmodule

// File: rtl/bst_tuner_checker.sv
`timescale 1ns/1ps
module bst_tuner_checker #(
  parameter int NUM_BANKS = 3,
  parameter int MAX_W     = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic                       cmp_valid_i,
  input logic [1:0]                 cmp_code_i,
  input logic                       cmp_ready_o,
  input logic [NUM_BANKS*MAX_W-1:0] tune_o,
  input logic                       restart_o,
  input logic                       close_loop_o,
  input logic                       done_o
);
  logic       acc;
  logic [7:0] steps_q;

  assign acc = cmp_valid_i && cmp_ready_o && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         steps_q <= '0;
    else if (start_i)   steps_q <= '0;
    else if (restart_o) steps_q <= acc ? 8'd1 : 8'd0;
    else if (acc)       steps_q <= steps_q + 8'd1;
  end

  assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (restart_o && !done_o && cmp_ready_o));

  assert_none_code_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmp_code_i == 2'b11)) |=> $stable(tune_o));

  assert_restart_close_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_o && close_loop_o));

  assert_done_with_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> close_loop_o);

  assert_ready_low_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmp_ready_o);

  assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    steps_q <= 8'(MAX_W));
endmodule

bind bst_tuner bst_tuner_checker #(
  .NUM_BANKS (NUM_BANKS),
  .MAX_W     (MAX_W)
) u_bst_tuner_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .cmp_valid_i  (cmp_valid_i),
  .cmp_code_i   (cmp_code_i),
  .cmp_ready_o  (cmp_ready_o),
  .tune_o       (tune_o),
  .restart_o    (restart_o),
  .close_loop_o (close_loop_o),
  .done_o       (done_o)
);

// File: tb/bst_tuner_bench.sv
`timescale 1ns/1ps
module bst_tuner_bench;
  localparam int NB = 3;
  localparam int W  = 7;
  localparam logic [1:0] HIT  = 2'b00;
  localparam logic [1:0] SLOW = 2'b01;
  localparam logic [1:0] FAST = 2'b10;
  localparam logic [1:0] NONE = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_valid_i = 1'b0;
  logic [1:0]    cmp_code_i = 2'b00;
  logic          cmp_ready_o, restart_o, close_loop_o, done_o;
  logic [NB*W-1:0] tune_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bst_tuner u_bst_tuner (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmp_valid_i  (cmp_valid_i),
    .cmp_code_i   (cmp_code_i),
    .cmp_ready_o  (cmp_ready_o),
    .tune_o       (tune_o),
    .restart_o    (restart_o),
    .close_loop_o (close_loop_o),
    .done_o       (done_o)
  );

  function automatic int word(input int b);
    return int'(tune_o[b*W +: W]);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_words(input string req, input int e0, input int e1, input int e2);
    chk(req, "bank0", word(0), e0);
    chk(req, "bank1", word(1), e1);
    chk(req, "bank2", word(2), e2);
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic step(input logic [1:0] code);
    @(negedge clk); cmp_valid_i = 1'b1; cmp_code_i = code;
    @(posedge clk); #1 cmp_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_words("R1", 0, 0, 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "ready", int'(cmp_ready_o), 0);
    chk("R1", "restart", int'(restart_o), 0);
    chk("R1", "close", int'(close_loop_o), 0);
  endtask

  task automatic t_slow_bank0();
    int exp_seq[4] = '{23, 27, 29, 30};
    do_start();
    chk_words("R2", 15, 0, 0);
    chk("R2", "restart", int'(restart_o), 1);
    chk("R2", "ready", int'(cmp_ready_o), 1);
    chk("R2", "done", int'(done_o), 0);
    foreach (exp_seq[i]) begin
      step(SLOW);
      chk("R3", "bank0 slow", word(0), exp_seq[i]);
      chk("R8", "bank1 unsearched", word(1), 0);
      chk("R2", "restart one cycle", int'(restart_o), 0);
    end
    step(SLOW);
    chk_words("R4", 30, 15, 0);
    chk("R9", "restart after 5 verdicts", int'(restart_o), 1);
  endtask

  task automatic t_fast_and_none();
    int exp_seq[3] = '{7, 3, 1};
    do_start();
    step(NONE);
    chk_words("R7", 15, 0, 0);
    chk("R7", "ready", int'(cmp_ready_o), 1);
    chk("R7", "restart", int'(restart_o), 0);
    foreach (exp_seq[i]) begin
      step(FAST);
      chk("R3", "bank0 fast", word(0), exp_seq[i]);
    end
    step(FAST);
    chk_words("R4", 0, 15, 0);
    chk("R4", "restart", int'(restart_o), 1);
    step(SLOW);
    chk_words("R8", 0, 23, 0);
  endtask

  task automatic t_restart_midway();
    do_start();
    chk_words("R2", 15, 0, 0);
    chk("R2", "restart", int'(restart_o), 1);
  endtask

  task automatic t_hit_path();
    int exp_seq[6] = '{95, 111, 119, 123, 125, 126};
    do_start();
    step(HIT);
    chk_words("R5", 14, 15, 0);
    chk("R5", "restart", int'(restart_o), 1);
    step(HIT);
    chk_words("R8", 14, 14, 63);
    foreach (exp_seq[i]) begin
      step(SLOW);
      chk("R3", "bank2 slow", word(2), exp_seq[i]);
      chk("R6", "close early", int'(close_loop_o), 0);
    end
    step(SLOW);
    chk_words("R6", 14, 14, 126);
    chk("R9", "close after 7 verdicts", int'(close_loop_o), 1);
    chk("R6", "done", int'(done_o), 1);
    chk("R6", "ready", int'(cmp_ready_o), 0);
    step(FAST);
    chk("R6", "close one cycle", int'(close_loop_o), 0);
    chk("R6", "done held", int'(done_o), 1);
    chk_words("R10", 14, 14, 126);
  endtask

  task automatic t_last_hit();
    do_start();
    chk("R6", "done cleared", int'(done_o), 0);
    step(HIT);
    step(HIT);
    step(HIT);
    chk_words("R6", 14, 14, 63);
    chk("R6", "close", int'(close_loop_o), 1);
    chk("R6", "done", int'(done_o), 1);
  endtask

  task automatic t_collision();
    do_start();
    step(SLOW);
    chk("R3", "bank0", word(0), 23);
    @(negedge clk); start_i = 1'b1; cmp_valid_i = 1'b1; cmp_code_i = SLOW;
    @(posedge clk); #1 start_i = 1'b0; cmp_valid_i = 1'b0;
    chk_words("R10", 15, 0, 0);
    chk("R10", "restart", int'(restart_o), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_slow_bank0();
    t_fast_and_none();
    t_restart_midway();
    t_hit_path();
    t_last_hit();
    t_collision();
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule